// File: doc/BRIEF.md
# Masked Open-Drain Line Control Register

This block is one 32-bit control register that lets software bit-bang a two-wire serial bus. It has a clock line and a data line. Each line has a direction bit, an output value bit and a pull-up-disable bit that software can write. It also has a read-only bit that returns the line's level after synchronisation. The direction and value bits are guarded by write-enable masks that are part of the same write. A write can therefore change the direction of one line, or its value, and leave every other field as it was. The only exception is the pull-up-disable bits: they are plain read/write bits, so software keeps them with a read-modify-write.

The block never drives a line high. A line goes low when its pad output enable is asserted, and the pad then drives 0. For a high level, software releases the line and the external pull-up sets the level. Each pad input passes through a two-flop synchroniser before software can read it. Software uses the block by writing mask-qualified patterns and reading back the synchronised input bits. Line 0 is the clock and line 1 is the data line.

Top module: `odl_gpio_reg`

## Requirements
- R1: After reset, both lines have direction = input (0), value = 0 and pull-up-disable = 0. Both pad output enables are low.
- R2: On a write, the direction bit of a line (bit 8k+2, 1 = output) takes the written value only if that line's direction-mask bit (bit 8k+1) is 1 in the same write. Otherwise it keeps its value.
- R3: On a write, the value bit of a line (bit 8k+4) takes the written value only if that line's value-mask bit (bit 8k+3) is 1 in the same write. Otherwise it keeps its value.
- R4: The pad output enable of a line is high exactly when its direction is output and its value is 0. This pulls the line low.
- R5: The line is released (output enable low) when its direction is input, whatever its value. It is also released when its direction is output and its value is 1. A line is never driven high.
- R6: Read bit 8k+5 returns the level of pad input k that was sampled two clock edges earlier. This holds whatever the line's direction.
- R7: The pull-up-disable bit of a line (bit 8k+0) takes the written value on every write, whatever the mask bits are. It is visible on output pullup_dis[k].
- R8: A write with all four mask bits 0 leaves direction and value of both lines unchanged. It changes only the pull-up-disable bits.
- R9: The mask bits, bits 8k+6 and 8k+7, and bits 16..31 always read as 0.
- R10: Without a write, direction, value and pull-up-disable bits hold their values.
- R11: Writing bit 8k+5 has no effect. Read bit 8k+5 still shows the synchronised pad level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data with per-line mask bits |
| rd_data | output | 32 | Register readback |
| pad_i | input | 2 | Pad input levels, index 0 clock, 1 data |
| pad_oe | output | 2 | Pad output enables; the pad drives 0 when asserted |
| pullup_dis | output | 2 | Pull-up disable per line |

## Verification
The properties assume that wr_en and wr_data are synchronous to clk and stable around the rising edge. They also assume that pad_i is a plain level with no relation to pad_oe. Because of that, the check of the synchroniser compares against the pad input itself and not against a modelled bus level. The bench drives every input on the falling edge and samples on the falling edge. It changes pad_i only between writes, so each input bit has two full edges to settle before it is compared.

// File: rtl/odl_pkg.sv
package odl_pkg;
    // Bit offsets inside one line's lane of the register
    localparam int unsigned F_PUD   = 0;
    localparam int unsigned F_DIR_M = 1;
    localparam int unsigned F_DIR   = 2;
    localparam int unsigned F_VAL_M = 3;
    localparam int unsigned F_VAL   = 4;
    localparam int unsigned F_IN    = 5;
    localparam int unsigned LANE_W  = 8;

    typedef struct packed {
        logic pud;
        logic dir;
        logic val;
    } line_cfg_t;
endpackage

// File: rtl/odl_line_ctl.sv
module odl_line_ctl
    import odl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] lane_wr,
    output line_cfg_t         cfg,
    output logic              oe
);
    line_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.pud = lane_wr[F_PUD];
            if (lane_wr[F_DIR_M]) cfg_d.dir = lane_wr[F_DIR];
            if (lane_wr[F_VAL_M]) cfg_d.val = lane_wr[F_VAL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
    // pull low only: output direction with a zero value
    assign oe  = cfg_q.dir & ~cfg_q.val;
endmodule

// File: rtl/odl_sync.sv
module odl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/odl_gpio_reg.sv
module odl_gpio_reg
    import odl_pkg::*;
#(
    parameter int unsigned LINES       = 2,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [LINES-1:0]  pad_i,
    output logic [LINES-1:0]  pad_oe,
    output logic [LINES-1:0]  pullup_dis
);
    localparam int unsigned USED_W = LINES * LANE_W;

    logic [LANE_W-1:0] lane_rd [LINES];

    for (genvar k = 0; k < LINES; k++) begin : g_line
        line_cfg_t cfg;
        logic      in_sync;

        odl_line_ctl u_ctl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .lane_wr (wr_data[k*LANE_W +: LANE_W]),
            .cfg     (cfg),
            .oe      (pad_oe[k])
        );

        odl_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (pad_i[k]),
            .dout  (in_sync)
        );

        assign pullup_dis[k] = cfg.pud;

        always_comb begin
            lane_rd[k]        = '0;
            lane_rd[k][F_PUD] = cfg.pud;
            lane_rd[k][F_DIR] = cfg.dir;
            lane_rd[k][F_VAL] = cfg.val;
            lane_rd[k][F_IN]  = in_sync;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < LINES; k++) begin
            rd_data[k*LANE_W +: LANE_W] = lane_rd[k];
        end
    end

    logic unused_hi;
    generate
        if (DATA_W > USED_W) begin : g_hi
            assign unused_hi = ^wr_data[DATA_W-1:USED_W];
        end else begin : g_nohi
            assign unused_hi = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/odl_gpio_reg_chk.sv
module odl_gpio_reg_chk
    import odl_pkg::*;
#(
    parameter int unsigned LINES       = 2,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [LINES-1:0]  pad_i,
    input logic [LINES-1:0]  pad_oe,
    input logic [LINES-1:0]  pullup_dis
);
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 3) age_q <= age_q + 2'd1;
    end

    for (genvar k = 0; k < LINES; k++) begin : g_chk
        localparam int unsigned B = k * LANE_W;

        assert_mask_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[B+F_DIR_M] == 1'b0 && rd_data[B+F_VAL_M] == 1'b0);

        assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_data[B+F_DIR_M]) |=> $stable(rd_data[B+F_DIR]));

        assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[B+F_DIR_M]) |=> rd_data[B+F_DIR] == $past(wr_data[B+F_DIR]));

        assert_val_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_data[B+F_VAL_M]) |=> $stable(rd_data[B+F_VAL]));

        assert_val_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[B+F_VAL_M]) |=> rd_data[B+F_VAL] == $past(wr_data[B+F_VAL]));

        assert_low_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[k] == (rd_data[B+F_DIR] && !rd_data[B+F_VAL]));

        assert_no_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[B+F_VAL] |-> !pad_oe[k]);

        assert_pud_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> pullup_dis[k] == $past(wr_data[B+F_PUD]));

        assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(pullup_dis[k]) && $stable(rd_data[B+F_DIR])
                       && $stable(rd_data[B+F_VAL]));

        if (SYNC_STAGES == 2) begin : g_sync2
            assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= 2) |-> rd_data[B+F_IN] == $past(pad_i[k], 2));
        end
    end
endmodule

bind odl_gpio_reg odl_gpio_reg_chk #(
    .LINES(LINES), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pad_i(pad_i), .pad_oe(pad_oe), .pullup_dis(pullup_dis)
);

// File: tb/sim_odl_gpio_reg.sv
module sim_odl_gpio_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [1:0]  pad_i;
    logic [1:0]  pad_oe;
    logic [1:0]  pullup_dis;

    int checks = 0;
    int errors = 0;
    logic mdir [2];
    logic mval [2];
    logic mpud [2];

    always #10 clk = ~clk;

    odl_gpio_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pad_i(pad_i), .pad_oe(pad_oe), .pullup_dis(pullup_dis)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [1:0] pin);
        logic [31:0] r = '0;
        for (int k = 0; k < 2; k++) begin
            r[8*k+0] = mpud[k];
            r[8*k+2] = mdir[k];
            r[8*k+4] = mval[k];
            r[8*k+5] = pin[k];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_oe();
        logic [31:0] r = '0;
        for (int k = 0; k < 2; k++) r[k] = mdir[k] & ~mval[k];
        return r;
    endfunction

    function automatic logic [31:0] exp_pud();
        logic [31:0] r = '0;
        for (int k = 0; k < 2; k++) r[k] = mpud[k];
        return r;
    endfunction

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        for (int k = 0; k < 2; k++) begin
            mpud[k] = d[8*k+0];
            if (d[8*k+1]) mdir[k] = d[8*k+2];
            if (d[8*k+3]) mval[k] = d[8*k+4];
        end
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic check_all(input string rdtag);
        chk(rdtag, rd_data, exp_rd(pad_i));
        chk("R4 R5 pad_oe", {30'd0, pad_oe}, exp_oe());
        chk("R7 pullup_dis", {30'd0, pullup_dis}, exp_pud());
    endtask

    task automatic sync_sweep(input string tag);
        for (int p = 0; p < 4; p++) begin
            logic [1:0] old = pad_i;
            @(negedge clk);
            pad_i = p[1:0];
            @(negedge clk);
            chk({tag, " one edge"}, rd_data, exp_rd(old));
            @(negedge clk);
            chk({tag, " two edges"}, rd_data, exp_rd(pad_i));
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin mdir[k] = 0; mval[k] = 0; mpud[k] = 0; end
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; pad_i = 2'b11;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1 R9 reset");

        sync_sweep("R6 released");
        wr(32'h0000_0E0E);      // both lines output low
        check_all("R4 pull low");
        sync_sweep("R6 driven low");

        wr(32'h0000_2121);      // input bits written, only pud set
        check_all("R11 R8 input bit read only");

        pad_i = 2'b10;
        repeat (2) @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 32; c++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [7:0]  st = {3'b000, s[1], 1'b1, s[0], 1'b1, 1'b1};
                    logic [31:0] d  = '0;
                    wr({16'h0, st, st});
                    d[8*k +: 8] = {3'b111, c[4:0]};   // upper junk incl. input bit
                    wr(d);
                    if (c[1] == 1'b0 && c[3] == 1'b0)
                        check_all("R8 R9 R11 mask-free write");
                    else
                        check_all("R2 R3 R9 masked write");
                end
            end
        end

        wr(32'hFFFF_1C01);
        repeat (4) @(negedge clk);
        check_all("R10 R9 idle hold");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule